// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM refreshed while the rest of the controller does its normal work. It also parks the memory safely when the logic around it is about to go away. A down-counter spreads single-row auto-refresh commands evenly over the retention period. Each interval is the period in clock cycles divided by the row count. When an interval expires, the block raises a refresh request toward the command path. It issues the auto-refresh command only after the command path grants the slot, which means it is idle and all banks are precharged.

A park request puts the memory into self-refresh. The block presents the auto-refresh encoding with the clock enable driven low, then holds the clock enable low for as long as the park request stays high. The memory then refreshes itself while the surrounding logic is reloaded. Any refresh that is already owed is issued before self-refresh entry, so no row is close to its deadline when the memory is parked. Dropping the park request raises the clock enable again. After a programmable exit time, normal refresh timing restarts from a full interval.

The command bits are decoded directly from the sequencer's state register. A grant sampled at one clock edge therefore shows up as a command in the cycle that follows that edge.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, the block drives cke high, the NOP encoding (cs_n=0, ras_n=1, cas_n=1, we_n=1), ref_req low and parked low.
- R2: The refresh interval is REF_INTERVAL = CLK_KHZ*REFRESH_MS/ROWS cycles. ref_req rises REF_INTERVAL clock edges after the block enters its running state, either from reset or at the end of a self-refresh exit. Later rises follow each other by exactly REF_INTERVAL cycles, however long each grant takes.
- R3: Suppose ref_req and cmd_idle are both high at a clock edge in the running state. The following cycle then carries the auto-refresh encoding (cs_n=0, ras_n=0, cas_n=0, we_n=1) with cke high, for exactly one cycle, and ref_req is low in that cycle.
- R4: While cmd_idle is low, no command other than NOP is driven and a raised ref_req stays high.
- R5: For the TRFC_CYC cycles after an auto-refresh, the block drives NOP with cke high and issues no further command.
- R6: Suppose no refresh is owed, and park_req and cmd_idle are high at a clock edge in the running state. The following cycle then carries the auto-refresh encoding with cke low (self-refresh entry), and parked rises in the cycle after that.
- R7: While parked is high, cke stays low, the bus carries NOP and ref_req stays low, for any parked length including periods longer than REF_INTERVAL.
- R8: If a refresh is owed when park is requested, the ordinary auto-refresh with cke high is issued first. Self-refresh entry follows two cycles after its TRFC_CYC recovery ends.
- R9: In the cycle after park_req is sampled low while parked, cke is high, parked is low and NOP is driven. The block then waits TXSR_CYC cycles before it counts a new interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| park_req | input | 1 | Request to hold the memory in self-refresh |
| cmd_idle | input | 1 | Grant: command path idle, banks precharged, slot free next cycle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| ref_req | output | 1 | A refresh is owed and waits for a grant |
| parked | output | 1 | Memory is held in self-refresh |

## Verification
The grant delay is swept from zero to five cycles. This separates a design that counts its interval from the request from one that counts it from the issued command, and it shows that requests are held while the slot is withheld. The park request is raised at every offset from the auto-refresh cycle up to just past the end of recovery. This distinguishes an entry that respects recovery from one that cuts into it, and each pass checks the exact exit-to-request distance. A final pattern raises park while a refresh is owed and the grant is withheld, which shows whether the owed refresh is ordered before self-refresh entry.

// File: rtl/sdram_ref_pkg.sv
`timescale 1ns/1ps
// Shared types for the refresh sequencer: sequencer states and the
// four-bit command encoding placed on the memory's control pins.
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,   // normal operation, counting the interval
        ST_AREF  = 3'd1,   // auto-refresh command cycle
        ST_RECOV = 3'd2,   // refresh recovery wait
        ST_SRE   = 3'd3,   // self-refresh entry cycle
        ST_PARK  = 3'd4,   // held in self-refresh
        ST_EXIT  = 3'd5    // self-refresh exit wait
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } mem_cmd_t;

    localparam mem_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam mem_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/ref_interval_timer.sv
`timescale 1ns/1ps
// Interval timer: counts INTERVAL cycles and then marks one refresh as
// owed. The count runs on while a request waits for a grant, so grant
// latency never stretches the average refresh rate.
// Assumes INTERVAL >= 2 and that ack arrives only while pending is high.
module ref_interval_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,      // self-refresh phases: freeze and re-arm
    input  logic ack,       // the owed refresh is being issued
    output logic pending
);
    localparam int CW = $clog2(INTERVAL);
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    // Count down the interval; set the owed flag on expiry, clear it on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= RELOAD;
            pending <= 1'b0;
        end else if (hold) begin
            cnt     <= RELOAD;
            pending <= 1'b0;
        end else if (cnt == '0) begin
            cnt     <= RELOAD;
            pending <= 1'b1;
        end else begin
            cnt <= cnt - CW'(1);
            if (ack) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ref_wait_timer.sv
`timescale 1ns/1ps
// Wait timer shared by refresh recovery and self-refresh exit.
// A load with sel=0 starts a RECOV_CYC wait and sel=1 starts an EXIT_CYC
// wait. done is high in the last cycle of the wait.
// Assumes both waits are at least one cycle.
module ref_wait_timer #(
    parameter int RECOV_CYC = 7,
    parameter int EXIT_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel,
    output logic done
);
    localparam int WMAX = (RECOV_CYC > EXIT_CYC) ? RECOV_CYC : EXIT_CYC;
    localparam int WW   = (WMAX > 1) ? $clog2(WMAX) : 1;
    localparam logic [WW-1:0] RECOV_LD = WW'(RECOV_CYC - 1);
    localparam logic [WW-1:0] EXIT_LD  = WW'(EXIT_CYC - 1);

    logic [WW-1:0] cnt;

    // Load the selected length or count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sel ? EXIT_LD : RECOV_LD;
        end else if (cnt != '0) begin
            cnt <= cnt - WW'(1);
        end
    end

    // The wait ends when the count reaches zero.
    always_comb done = (cnt == '0);
endmodule

// File: rtl/ref_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencer state machine. An owed refresh takes precedence over park
// entry. Both need the command-path grant, and both start only from the
// running state, so recovery is never cut short.
module ref_seq_ctrl
    import sdram_ref_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending,
    input  logic       cmd_idle,
    input  logic       park_req,
    input  logic       wait_done,
    output seq_state_t state,
    output logic       ack,
    output logic       wait_load,
    output logic       wait_sel
);
    seq_state_t nxt;

    // Next-state and control decode.
    always_comb begin
        nxt       = state;
        ack       = 1'b0;
        wait_load = 1'b0;
        wait_sel  = 1'b0;
        case (state)
            ST_RUN: begin
                if (cmd_idle && pending) begin
                    nxt = ST_AREF;
                    ack = 1'b1;
                end else if (cmd_idle && park_req) begin
                    nxt = ST_SRE;
                end
            end
            ST_AREF: begin
                nxt       = ST_RECOV;
                wait_load = 1'b1;
            end
            ST_RECOV: if (wait_done) nxt = ST_RUN;
            ST_SRE:   nxt = ST_PARK;
            ST_PARK: begin
                wait_load = 1'b1;
                wait_sel  = 1'b1;
                if (!park_req) nxt = ST_EXIT;
            end
            ST_EXIT:  if (wait_done) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end
endmodule

// File: rtl/ref_cmd_decode.sv
`timescale 1ns/1ps
// Pin decode. The command bits, clock enable and parked flag all come
// from the state register, so the pins change only on clock edges.
module ref_cmd_decode
    import sdram_ref_pkg::*;
(
    input  seq_state_t state,
    output mem_cmd_t   cmd,
    output logic       cke,
    output logic       parked
);
    // Refresh encoding in both command states; clock enable low only around self-refresh.
    always_comb begin
        cmd    = (state == ST_AREF || state == ST_SRE) ? CMD_AREF : CMD_NOP;
        cke    = !(state == ST_SRE || state == ST_PARK);
        parked = (state == ST_PARK);
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
`timescale 1ns/1ps
// SDRAM refresh and self-refresh sequencer (top).
// The interval is CLK_KHZ*REFRESH_MS/ROWS cycles. Refresh needs a grant
// on cmd_idle. A park request is served by an owed refresh first, then
// by self-refresh entry with cke low, held until the request drops.
// Assumes TRFC_CYC + 8 < REF_INTERVAL and a grant that, once seen, frees
// the next cycle.
module sdram_refresh_seq
    import sdram_ref_pkg::*;
#(
    parameter int CLK_KHZ    = 100000,
    parameter int REFRESH_MS = 64,
    parameter int ROWS       = 8192,
    parameter int TRFC_CYC   = 7,
    parameter int TXSR_CYC   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic park_req,
    input  logic cmd_idle,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke,
    output logic ref_req,
    output logic parked
);
    localparam int REF_INTERVAL = CLK_KHZ * REFRESH_MS / ROWS;

    seq_state_t state;
    mem_cmd_t   cmd;
    logic       pending, ack, hold, wait_load, wait_sel, wait_done;

    // Interval counting pauses for every self-refresh phase.
    always_comb hold = (state == ST_SRE) || (state == ST_PARK) || (state == ST_EXIT);

    ref_interval_timer #(.INTERVAL(REF_INTERVAL)) i_interval (
        .clk(clk), .rst_n(rst_n), .hold(hold), .ack(ack), .pending(pending)
    );

    ref_wait_timer #(.RECOV_CYC(TRFC_CYC), .EXIT_CYC(TXSR_CYC)) i_wait (
        .clk(clk), .rst_n(rst_n), .load(wait_load), .sel(wait_sel), .done(wait_done)
    );

    ref_seq_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .pending(pending), .cmd_idle(cmd_idle),
        .park_req(park_req), .wait_done(wait_done), .state(state),
        .ack(ack), .wait_load(wait_load), .wait_sel(wait_sel)
    );

    ref_cmd_decode i_decode (
        .state(state), .cmd(cmd), .cke(cke), .parked(parked)
    );

    // Drive the pins.
    always_comb begin
        cs_n    = cmd.cs_n;
        ras_n   = cmd.ras_n;
        cas_n   = cmd.cas_n;
        we_n    = cmd.we_n;
        ref_req = pending;
    end
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
`timescale 1ns/1ps
// Port-level checker for the refresh sequencer, bound to every instance.
module sdram_refresh_seq_chk #(
    parameter int TRFC_CYC = 7
) (
    input logic clk,
    input logic rst_n,
    input logic park_req,
    input logic cmd_idle,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cke,
    input logic ref_req,
    input logic parked
);
    localparam int GW = $clog2(TRFC_CYC + 2) + 1;

    logic          ar_bus, nop_bus, seen_ar;
    logic [GW-1:0] gap;

    always_comb begin
        ar_bus  = !cs_n && !ras_n && !cas_n && we_n;
        nop_bus = !cs_n && ras_n && cas_n && we_n;
    end

    // Cycles since the last refresh encoding, saturating just past recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= '0;
            seen_ar <= 1'b0;
        end else if (ar_bus) begin
            gap     <= '0;
            seen_ar <= 1'b1;
        end else if (gap <= GW'(TRFC_CYC)) begin
            gap <= gap + GW'(1);
        end
    end

    assert_ar_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_bus && cke) |-> ($past(ref_req) && $past(cmd_idle) && !ref_req));

    assert_ar_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ar_bus |=> !ar_bus);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !cmd_idle) |=> (ref_req && nop_bus));

    assert_recovery_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_bus && seen_ar) |-> (gap > GW'(TRFC_CYC)));

    assert_sre_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (ar_bus && $past(park_req) && $past(cmd_idle) && !$past(ref_req)));

    assert_parked_after_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_bus && !cke) |=> parked);

    assert_parked_cke_R7: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> (!cke && nop_bus && !ref_req));

    assert_exit_cke_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(parked) |-> (cke && nop_bus && !$past(park_req)));
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(.TRFC_CYC(TRFC_CYC)) i_chk (.*);

// File: tb/test_sdram_refresh_seq.sv
`timescale 1ns/1ps
// Bench: sweeps the grant delay and the park offset on a small
// configuration and computes every expected cycle arithmetically.
module test_sdram_refresh_seq;
    localparam int CLK_KHZ = 160, REFRESH_MS = 1, ROWS = 8;
    localparam int TRFC = 3, TXSR = 4;
    localparam int IVL  = CLK_KHZ * REFRESH_MS / ROWS;   // 20 cycles
    // Pin codes {cke, cs_n, ras_n, cas_n, we_n}
    localparam int P_NOP  = 5'b10111;
    localparam int P_AR   = 5'b10001;
    localparam int P_SRE  = 5'b00001;
    localparam int P_PNOP = 5'b00111;

    logic clk = 1'b0, rst_n = 1'b0, park_req = 1'b0, cmd_idle = 1'b1;
    logic cs_n, ras_n, cas_n, we_n, cke, ref_req, parked;
    int   cyc = 0, total = 0, bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    sdram_refresh_seq #(.CLK_KHZ(CLK_KHZ), .REFRESH_MS(REFRESH_MS), .ROWS(ROWS),
                        .TRFC_CYC(TRFC), .TXSR_CYC(TXSR)) i_sdram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .park_req(park_req), .cmd_idle(cmd_idle),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ref_req(ref_req), .parked(parked)
    );

    function automatic int pins();
        return int'({cke, cs_n, ras_n, cas_n, we_n});
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_rise(output int at);
        for (int n = 0; n < 4 * IVL && !ref_req; n++) step();
        at = cyc;
    endtask

    initial begin
        int r, prev, a, x, y, errs;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(pins() == P_NOP, "R1 reset pins", pins(), P_NOP);
        chk(!ref_req && !parked, "R1 reset flags", {ref_req, parked}, 0);
        rst_n = 1'b1;
        prev = cyc;
        step();
        chk(pins() == P_NOP && !ref_req && !parked, "R1 first cycle", pins(), P_NOP);
        wait_rise(r);
        chk(r - prev == IVL, "R2 first request", r - prev, IVL);
        step();
        chk(pins() == P_AR, "R3 refresh pins", pins(), P_AR);
        chk(!ref_req, "R3 request cleared", ref_req, 0);
        cmd_idle = 1'b0;
        for (int k = 1; k <= TRFC; k++) begin
            step();
            chk(pins() == P_NOP && !ref_req, "R5 recovery nop", pins(), P_NOP);
        end
        prev = r;
        // Grant-delay sweep: R2, R3, R4
        for (int d = 0; d <= 5; d++) begin
            wait_rise(r);
            chk(r - prev == IVL, "R2 period", r - prev, IVL);
            for (int k = 1; k <= d; k++) begin
                step();
                chk(pins() == P_NOP && ref_req, "R4 held without grant", pins(), P_NOP);
            end
            cmd_idle = 1'b1;
            step();
            chk(pins() == P_AR && !ref_req, "R3 refresh after grant", pins(), P_AR);
            chk(cyc == r + d + 1, "R3 refresh cycle", cyc - r, d + 1);
            cmd_idle = 1'b0;
            prev = r;
        end
        // Park-offset sweep: R6, R7, R9
        cmd_idle = 1'b1;
        wait_rise(r);
        for (int p = 0; p <= TRFC + 2; p++) begin
            step();
            a = cyc;
            chk(pins() == P_AR && a == r + 1, "R3 refresh before park", pins(), P_AR);
            for (int k = 0; k < p; k++) step();
            park_req = 1'b1;
            x = (a + TRFC + 1 > a + p) ? a + TRFC + 1 : a + p;
            for (int n = 0; n < 20 && cke; n++) step();
            chk(cyc == x + 1, "R6 entry cycle", cyc - a, x + 1 - a);
            chk(pins() == P_SRE && !parked, "R6 entry pins", pins(), P_SRE);
            step();
            chk(pins() == P_PNOP && parked, "R6 parked flag", pins(), P_PNOP);
            errs = 0;
            for (int k = 0; k < 2 * IVL; k++) begin
                step();
                if (pins() != P_PNOP || !parked || ref_req) errs++;
            end
            chk(errs == 0, "R7 held low while parked", errs, 0);
            park_req = 1'b0;
            y = cyc;
            step();
            chk(pins() == P_NOP && !parked, "R9 exit pins", pins(), P_NOP);
            wait_rise(r);
            chk(r == y + 1 + TXSR + IVL, "R9 exit to first request", r - y, 1 + TXSR + IVL);
        end
        // Owed refresh before entry: R8
        step();
        cmd_idle = 1'b0;
        wait_rise(r);
        park_req = 1'b1;
        for (int k = 0; k < 2; k++) begin
            step();
            chk(pins() == P_NOP && ref_req, "R8 no entry without grant", pins(), P_NOP);
        end
        cmd_idle = 1'b1;
        step();
        chk(pins() == P_AR, "R8 owed refresh first", pins(), P_AR);
        for (int n = 0; n < 20 && cke; n++) step();
        chk(cyc == r + 3 + TRFC + 2, "R8 entry after recovery", cyc - r, 5 + TRFC);
        chk(pins() == P_SRE, "R8 entry pins", pins(), P_SRE);
        step();
        park_req = 1'b0;
        step();
        step();
        chk(cke && !parked, "R9 released", {cke, parked}, 2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule